// File: doc/BRIEF.md
# Predicated In-Place Tree Reduction Sequencer

This block reduces the active elements of a short vector to one value by a pairwise tree, one candidate pair per clock. A slot takes part only when its bit in the predicate mask is set and its index is below the programmed length. Elements are never moved. When a slot is empty and its partner holds data, the slot is pointed at the partner's element through an index-redirection table. Partial sums always build up in the lowest-indexed active element of each subtree. The element storage sits outside the block and is reached through two combinational read ports and one write port.

The only state that must survive a context switch is the progress pair: the pass level and the slot of the next pair still to be processed. On resume, the block replays every earlier pair with the element ports idle. This rebuilds the redirection table and the working mask. It then continues from the saved pair, so the final result matches an uninterrupted run. The combine operation is chosen by a parameter and defaults to wrapping addition.

Top module: `tree_reduce_seq`

## Requirements
- R1: After `done_o`, `res_idx_o` is the lowest index k < `vl_i` with `pred_i[k]` set. The element at that index holds the DW-bit wrapping sum of all such active elements.
- R2: `res_valid_o` is low after `done_o` exactly when no bit of `pred_i` below `vl_i` is set. Mask bits at or above `vl_i` have no effect.
- R3: For length n, pass s = 0, 1, … (stride 2^(s+1)) runs while 2^s < n and visits ceil(n / 2^(s+1)) slots. `done_o` goes high for exactly one cycle, N rising edges after the start edge, where N is the total number of slot visits.
- R4: An element whose predicate bit is clear, or whose index is at or above `vl_i`, is never written.
- R5: The read ports are enabled only when both pair members are active. The redirected partner index is then below `vl_i` and above the current element index. Writes occur only alongside such reads.
- R6: `prog_lvl_o`/`prog_pos_o` give the pass number (stride 2^(lvl+1)) and the slot of the next pair not yet processed. Both are zero after reset, when `busy_o` and `done_o` are low.
- R7: `abort_i` (when neither `start_i` nor `resume_i` is high) stops the block at the next edge. It processes no pair, gives no `done_o`, and leaves the progress outputs unchanged.
- R8: `resume_i` with a saved progress pair replays the earlier pairs with no element access, one per cycle, then continues. `done_o` appears N edges after the resume edge, and the result equals an uninterrupted run.
- R9: A length of 0 or 1 gives `done_o` one cycle after the start edge, with no element access. For length 1, the result index is 0 and validity equals `pred_i[0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a fresh reduction |
| resume_i | input | 1 | Begin from saved progress |
| abort_i | input | 1 | Stop before the next pair |
| vl_i | input | VW | Vector length, held for the whole operation |
| pred_i | input | MAX_VL | Predicate mask, held for the whole operation |
| prog_lvl_i | input | LW | Saved pass level for resume |
| prog_pos_i | input | IW | Saved slot for resume |
| prog_lvl_o | output | LW | Current pass level |
| prog_pos_o | output | IW | Next slot to process |
| busy_o | output | 1 | Reduction or replay in progress |
| done_o | output | 1 | One-cycle completion pulse |
| res_idx_o | output | IW | Element index holding the result |
| res_valid_o | output | 1 | At least one active element existed |
| rd_en_o | output | 1 | Read ports in use this cycle |
| rd_a_idx_o | output | IW | Accumulator element index |
| rd_b_idx_o | output | IW | Partner element index |
| rd_a_data_i | input | DW | Element data at rd_a_idx_o |
| rd_b_data_i | input | DW | Element data at rd_b_idx_o |
| wr_en_o | output | 1 | Element write enable |
| wr_idx_o | output | IW | Element write index |
| wr_data_o | output | DW | Combined value to write |

## Verification
The assertions take for granted that `vl_i` and `pred_i` stay stable from the start or resume edge until completion. They also assume that any progress pair handed back on resume is one the block itself reported after an abort. The stimulus keeps within this: it changes the length and mask only while the block is idle. It resumes only with the level and slot read from the progress outputs after an abort, and it applies the same length and mask as the interrupted run. Abort points are placed inside the first pass and across the pass boundary, as well as at the very first pair.

// File: rtl/tree_reduce_pkg.sv
package tree_reduce_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_REPLAY = 2'd1,
    ST_RUN    = 2'd2
  } seq_st_e;

  typedef enum logic {
    OP_ADD = 1'b0,
    OP_XOR = 1'b1
  } comb_op_e;
endpackage

// File: rtl/tr_step_ctrl.sv
module tr_step_ctrl
  import tree_reduce_pkg::*;
#(
  parameter int MAX_VL = 8,
  parameter int IW = 3,
  parameter int VW = 4,
  parameter int LW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          resume_i,
  input  logic          abort_i,
  input  logic [VW-1:0] vl_i,
  input  logic [LW-1:0] prog_lvl_i,
  input  logic [IW-1:0] prog_pos_i,
  output logic [LW-1:0] lvl_o,
  output logic [IW-1:0] pos_o,
  output logic [VW-1:0] vl_o,
  output logic          proc_o,
  output logic          replay_o,
  output logic          busy_o,
  output logic          done_o
);
  localparam int WW = VW + 2;

  seq_st_e       st_q;
  logic [LW-1:0] lvl_q, tgt_lvl_q, nlvl;
  logic [IW-1:0] pos_q, tgt_pos_q, npos;
  logic [VW-1:0] vl_q;
  logic          done_q, wrap, last;
  logic [WW-1:0] npos_w;

  always_comb begin
    npos_w = WW'(pos_q) + (WW'(2) << lvl_q);
    wrap   = npos_w >= WW'(vl_q);
    nlvl   = wrap ? lvl_q + LW'(1) : lvl_q;
    npos   = wrap ? '0 : npos_w[IW-1:0];
    last   = (WW'(1) << nlvl) >= WW'(vl_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      lvl_q     <= '0;
      pos_q     <= '0;
      tgt_lvl_q <= '0;
      tgt_pos_q <= '0;
      vl_q      <= '0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i || resume_i) begin
        vl_q      <= vl_i;
        lvl_q     <= '0;
        pos_q     <= '0;
        tgt_lvl_q <= prog_lvl_i;
        tgt_pos_q <= prog_pos_i;
        if (vl_i <= VW'(1)) begin
          st_q   <= ST_IDLE;
          done_q <= 1'b1;
        end else if (start_i || (prog_lvl_i == '0 && prog_pos_i == '0)) begin
          st_q <= ST_RUN;
        end else begin
          st_q <= ST_REPLAY;
        end
      end else if (abort_i) begin
        st_q <= ST_IDLE;
      end else if (st_q != ST_IDLE) begin
        lvl_q <= nlvl;
        pos_q <= npos;
        if (last) begin
          st_q   <= ST_IDLE;
          done_q <= 1'b1;
        end else if (st_q == ST_REPLAY && nlvl == tgt_lvl_q && npos == tgt_pos_q) begin
          st_q <= ST_RUN;
        end
      end
    end
  end

  assign lvl_o    = lvl_q;
  assign pos_o    = pos_q;
  assign vl_o     = vl_q;
  assign busy_o   = st_q != ST_IDLE;
  assign replay_o = st_q == ST_REPLAY;
  assign proc_o   = busy_o && !start_i && !resume_i && !abort_i;
  assign done_o   = done_q;

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q); // R3
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> st_q == ST_IDLE); // R3
  AST_ABORT_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_i && !start_i && !resume_i) |=> (st_q == ST_IDLE && !done_q)); // R7
  AST_ABORT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_i && !start_i && !resume_i) |=> ($stable(lvl_q) && $stable(pos_q))); // R7
  AST_REPLAY_BEHIND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_REPLAY) |-> lvl_q <= tgt_lvl_q); // R8
endmodule

// File: rtl/tr_redir_table.sv
module tr_redir_table #(
  parameter int MAX_VL = 8,
  parameter int IW = 3,
  parameter int VW = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       init_i,
  input  logic [VW-1:0]              vl_i,
  input  logic [MAX_VL-1:0]          pred_i,
  input  logic                       upd_en_i,
  input  logic [IW-1:0]              upd_pos_i,
  input  logic [IW-1:0]              upd_val_i,
  output logic [MAX_VL-1:0][IW-1:0]  redir_o,
  output logic [MAX_VL-1:0]          wpred_o
);
  logic [MAX_VL-1:0][IW-1:0] redir_q;
  logic [MAX_VL-1:0]         wpred_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < MAX_VL; k++) redir_q[k] <= IW'(k);
      wpred_q <= '0;
    end else if (init_i) begin
      for (int k = 0; k < MAX_VL; k++) begin
        redir_q[k] <= IW'(k);
        wpred_q[k] <= pred_i[k] && (VW'(k) < vl_i);
      end
    end else if (upd_en_i) begin
      redir_q[upd_pos_i] <= upd_val_i;
      wpred_q[upd_pos_i] <= 1'b1;
    end
  end

  assign redir_o = redir_q;
  assign wpred_o = wpred_q;

  for (genvar k = 0; k < MAX_VL; k++) begin : g_chk
    if (k > 0) begin : g_fwd
      AST_REDIR_FWD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        redir_q[k] >= IW'(k)); // R1
    end
    AST_WPRED_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wpred_q[k] && !init_i) |=> wpred_q[k]); // R1
  end
endmodule

// File: rtl/tr_pair_unit.sv
module tr_pair_unit
  import tree_reduce_pkg::*;
#(
  parameter int MAX_VL = 8,
  parameter int IW = 3,
  parameter int VW = 4,
  parameter int LW = 2,
  parameter int DW = 16,
  parameter comb_op_e OP = OP_ADD
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [LW-1:0]             lvl_i,
  input  logic [IW-1:0]             pos_i,
  input  logic [VW-1:0]             vl_i,
  input  logic                      proc_i,
  input  logic                      replay_i,
  input  logic [MAX_VL-1:0][IW-1:0] redir_i,
  input  logic [MAX_VL-1:0]         wpred_i,
  input  logic [DW-1:0]             rd_a_data_i,
  input  logic [DW-1:0]             rd_b_data_i,
  output logic                      rd_en_o,
  output logic [IW-1:0]             rd_a_idx_o,
  output logic [IW-1:0]             rd_b_idx_o,
  output logic                      wr_en_o,
  output logic [IW-1:0]             wr_idx_o,
  output logic [DW-1:0]             wr_data_o,
  output logic                      upd_en_o,
  output logic [IW-1:0]             upd_pos_o,
  output logic [IW-1:0]             upd_val_o
);
  localparam int WW = VW + 2;

  logic [WW-1:0] ppos_w;
  logic [IW-1:0] ppos, other, home;
  logic          part_in, part_act, cur_act, pair_act;
  logic [DW-1:0] comb;

  always_comb begin
    ppos_w   = WW'(pos_i) + (WW'(1) << lvl_i);
    part_in  = ppos_w < WW'(vl_i);
    ppos     = ppos_w[IW-1:0];
    other    = part_in ? redir_i[ppos] : '0;
    part_act = part_in && wpred_i[ppos] && (WW'(other) < WW'(vl_i));
    cur_act  = wpred_i[pos_i];
    home     = redir_i[pos_i];
    pair_act = proc_i && !replay_i && cur_act && part_act;
  end

  if (OP == OP_XOR) begin : g_xor
    assign comb = rd_a_data_i ^ rd_b_data_i;
  end else begin : g_add
    assign comb = rd_a_data_i + rd_b_data_i;
  end

  assign rd_en_o    = pair_act;
  assign rd_a_idx_o = pair_act ? home : '0;
  assign rd_b_idx_o = pair_act ? other : '0;
  assign wr_en_o    = pair_act;
  assign wr_idx_o   = pair_act ? home : '0;
  assign wr_data_o  = pair_act ? comb : '0;
  // bypass an empty slot by pointing it at the partner's element
  assign upd_en_o   = proc_i && !cur_act && part_act;
  assign upd_pos_o  = pos_i;
  assign upd_val_o  = other;

  AST_RD_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o |-> (WW'(rd_b_idx_o) < WW'(vl_i) && rd_a_idx_o < rd_b_idx_o)); // R5
  AST_NO_ACCESS_REPLAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    replay_i |-> !(rd_en_o || wr_en_o)); // R8
  AST_UPD_FORWARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_en_o |-> upd_val_o > upd_pos_o); // R1
endmodule

// File: rtl/tree_reduce_seq.sv
module tree_reduce_seq
  import tree_reduce_pkg::*;
#(
  parameter int MAX_VL = 8,
  parameter int DW = 16,
  parameter comb_op_e OP = OP_ADD,
  localparam int IW = $clog2(MAX_VL),
  localparam int VW = $clog2(MAX_VL + 1),
  localparam int LW = $clog2(IW + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              resume_i,
  input  logic              abort_i,
  input  logic [VW-1:0]     vl_i,
  input  logic [MAX_VL-1:0] pred_i,
  input  logic [LW-1:0]     prog_lvl_i,
  input  logic [IW-1:0]     prog_pos_i,
  output logic [LW-1:0]     prog_lvl_o,
  output logic [IW-1:0]     prog_pos_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [IW-1:0]     res_idx_o,
  output logic              res_valid_o,
  output logic              rd_en_o,
  output logic [IW-1:0]     rd_a_idx_o,
  output logic [IW-1:0]     rd_b_idx_o,
  input  logic [DW-1:0]     rd_a_data_i,
  input  logic [DW-1:0]     rd_b_data_i,
  output logic              wr_en_o,
  output logic [IW-1:0]     wr_idx_o,
  output logic [DW-1:0]     wr_data_o
);
  logic [LW-1:0]             lvl;
  logic [IW-1:0]             pos, upd_pos, upd_val;
  logic [VW-1:0]             vl_q;
  logic                      proc, replay, upd_en;
  logic [MAX_VL-1:0][IW-1:0] redir;
  logic [MAX_VL-1:0]         wpred;

  tr_step_ctrl #(.MAX_VL(MAX_VL), .IW(IW), .VW(VW), .LW(LW)) ctrl_i (
    .clk_i, .rst_ni, .start_i, .resume_i, .abort_i, .vl_i,
    .prog_lvl_i, .prog_pos_i,
    .lvl_o(lvl), .pos_o(pos), .vl_o(vl_q), .proc_o(proc),
    .replay_o(replay), .busy_o, .done_o
  );

  tr_redir_table #(.MAX_VL(MAX_VL), .IW(IW), .VW(VW)) tbl_i (
    .clk_i, .rst_ni, .init_i(start_i || resume_i), .vl_i, .pred_i,
    .upd_en_i(upd_en), .upd_pos_i(upd_pos), .upd_val_i(upd_val),
    .redir_o(redir), .wpred_o(wpred)
  );

  tr_pair_unit #(.MAX_VL(MAX_VL), .IW(IW), .VW(VW), .LW(LW), .DW(DW), .OP(OP)) pair_i (
    .clk_i, .rst_ni, .lvl_i(lvl), .pos_i(pos), .vl_i(vl_q),
    .proc_i(proc), .replay_i(replay), .redir_i(redir), .wpred_i(wpred),
    .rd_a_data_i, .rd_b_data_i, .rd_en_o, .rd_a_idx_o, .rd_b_idx_o,
    .wr_en_o, .wr_idx_o, .wr_data_o,
    .upd_en_o(upd_en), .upd_pos_o(upd_pos), .upd_val_o(upd_val)
  );

  assign prog_lvl_o  = lvl;
  assign prog_pos_o  = pos;
  assign res_idx_o   = redir[0];
  assign res_valid_o = wpred[0];
endmodule

// File: tb/tree_reduce_seq_tb_top.sv
`timescale 1ns/1ps
module tree_reduce_seq_tb_top;
  localparam int MAX_VL = 8;
  localparam int DW = 16;
  localparam int IW = $clog2(MAX_VL);
  localparam int VW = $clog2(MAX_VL + 1);
  localparam int LW = $clog2(IW + 1);

  typedef struct packed {
    logic [VW-1:0]     vl;
    logic [MAX_VL-1:0] pred;
    logic [DW-1:0]     seed;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{4'd8, 8'hFF, 16'hFFF0},
    '{4'd8, 8'h00, 16'h1234},
    '{4'd8, 8'h80, 16'h00A5},
    '{4'd5, 8'h1A, 16'h7FFF},
    '{4'd3, 8'hF8, 16'h0101},
    '{4'd7, 8'h54, 16'hC3C3},
    '{4'd6, 8'h21, 16'h8001},
    '{4'd2, 8'h02, 16'h0F0F}
  };

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0, resume_i = 1'b0, abort_i = 1'b0;
  logic [VW-1:0] vl_i = '0;
  logic [MAX_VL-1:0] pred_i = '0;
  logic [LW-1:0] prog_lvl_i = '0, prog_lvl_o;
  logic [IW-1:0] prog_pos_i = '0, prog_pos_o;
  logic busy_o, done_o, res_valid_o, rd_en_o, wr_en_o;
  logic [IW-1:0] res_idx_o, rd_a_idx_o, rd_b_idx_o, wr_idx_o;
  logic [DW-1:0] rd_a_data_i, rd_b_data_i, wr_data_o;

  logic [DW-1:0] mem [MAX_VL];
  logic [DW-1:0] img [MAX_VL];
  logic ld_en = 1'b0;
  logic [IW-1:0] ld_idx = '0;
  logic [DW-1:0] ld_data = '0;
  int checks = 0, fails = 0, viol5 = 0, reads = 0;
  int cur_vl = 0;
  logic [MAX_VL-1:0] cur_pred = '0;

  always #2 clk_i = ~clk_i;

  tree_reduce_seq dut_i (.*);

  assign rd_a_data_i = mem[rd_a_idx_o];
  assign rd_b_data_i = mem[rd_b_idx_o];

  always @(posedge clk_i) begin
    if (wr_en_o) mem[wr_idx_o] <= wr_data_o;
    else if (ld_en) mem[ld_idx] <= ld_data;
  end

  always @(negedge clk_i) begin
    if (rst_ni && rd_en_o) begin
      reads++;
      if (!(int'(rd_b_idx_o) < cur_vl && cur_pred[rd_a_idx_o] && cur_pred[rd_b_idx_o]
            && rd_a_idx_o < rd_b_idx_o && wr_idx_o == rd_a_idx_o)) viol5++;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int pairs(input int vl);
    int n = 0;
    for (int st = 2; st / 2 < vl; st *= 2) n += (vl + st - 1) / st;
    return n;
  endfunction

  function automatic void pair_at(input int vl, input int k, output int lv, output int ps);
    int n = 0;
    int l = 0;
    lv = 0; ps = 0;
    for (int st = 2; st / 2 < vl; st *= 2) begin
      for (int i = 0; i < vl; i += st) begin
        if (n == k) begin lv = l; ps = i; return; end
        n++;
      end
      l++;
    end
    lv = l; ps = 0;
  endfunction

  task automatic load(input logic [DW-1:0] seed);
    for (int k = 0; k < MAX_VL; k++) begin
      img[k] = DW'(seed + DW'(k * (k + 3) * 37));
      @(negedge clk_i);
      ld_en = 1'b1; ld_idx = IW'(k); ld_data = img[k];
    end
    @(negedge clk_i);
    ld_en = 1'b0;
  endtask

  task automatic wait_done(input int lat0, output int lat);
    lat = lat0;
    while (!done_o && lat < 100) begin
      @(negedge clk_i);
      lat++;
    end
  endtask

  task automatic check_result(input int vl, input logic [MAX_VL-1:0] pred, input string tag);
    logic [DW-1:0] sum = '0;
    int first = -1;
    int bad4 = 0;
    for (int k = 0; k < vl; k++) if (pred[k]) begin
      sum += img[k];
      if (first < 0) first = k;
    end
    chk(res_valid_o == (first >= 0), {tag, " R2 valid"}, res_valid_o, first >= 0);
    if (first >= 0) begin
      chk(int'(res_idx_o) == first, {tag, " R1 index"}, res_idx_o, first);
      chk(mem[res_idx_o] == sum, {tag, " R1 sum"}, mem[res_idx_o], sum);
    end
    for (int k = 0; k < MAX_VL; k++)
      if (!(k < vl && pred[k]) && mem[k] != img[k]) bad4++;
    chk(bad4 == 0, {tag, " R4 inactive untouched"}, bad4, 0);
  endtask

  task automatic run_vec(input int vl, input logic [MAX_VL-1:0] pred,
                         input logic [DW-1:0] seed, input string tag);
    int lat;
    load(seed);
    cur_vl = vl; cur_pred = pred;
    @(negedge clk_i);
    vl_i = VW'(vl); pred_i = pred; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    wait_done(0, lat);
    chk(lat == pairs(vl), {tag, " R3 latency"}, lat, pairs(vl));
    check_result(vl, pred, tag);
    @(negedge clk_i);
    chk(!done_o && !busy_o, {tag, " R3 done one cycle"}, done_o, 0);
  endtask

  task automatic abort_resume(input int k);
    int vl = 8;
    logic [MAX_VL-1:0] pred = 8'hB6;
    int lv, ps, lat, acc;
    load(16'h4321);
    cur_vl = vl; cur_pred = pred;
    @(negedge clk_i);
    vl_i = VW'(vl); pred_i = pred; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (k) @(negedge clk_i);
    abort_i = 1'b1;
    @(negedge clk_i);
    abort_i = 1'b0;
    pair_at(vl, k, lv, ps);
    chk(!busy_o, "R7 abort stops", busy_o, 0);
    chk(int'(prog_lvl_o) == lv && int'(prog_pos_o) == ps, "R6 progress after abort",
        {prog_lvl_o, prog_pos_o}, {lv[LW-1:0], ps[IW-1:0]});
    acc = 0;
    repeat (3) begin
      @(negedge clk_i);
      if (done_o || busy_o || rd_en_o || wr_en_o) acc++;
    end
    chk(acc == 0 && int'(prog_lvl_o) == lv && int'(prog_pos_o) == ps,
        "R7 idle and held after abort", acc, 0);
    prog_lvl_i = prog_lvl_o; prog_pos_i = prog_pos_o; resume_i = 1'b1;
    @(negedge clk_i);
    resume_i = 1'b0;
    acc = 0;
    for (int j = 0; j < k; j++) begin
      if (rd_en_o || wr_en_o || done_o) acc++;
      @(negedge clk_i);
    end
    chk(acc == 0, "R8 replay without access", acc, 0);
    wait_done(k, lat);
    chk(lat == pairs(vl), "R8 resume latency", lat, pairs(vl));
    check_result(vl, pred, "R8 resumed");
    @(negedge clk_i);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int lat;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!busy_o && !done_o && !rd_en_o && !wr_en_o, "R6 reset idle",
        {busy_o, done_o, rd_en_o, wr_en_o}, 0);
    chk(prog_lvl_o == '0 && prog_pos_o == '0, "R6 reset progress",
        {prog_lvl_o, prog_pos_o}, 0);

    for (int v = 0; v < NV; v++)
      run_vec(int'(VECS[v].vl), VECS[v].pred, VECS[v].seed, $sformatf("vec%0d", v));

    // R9 short lengths
    for (int t = 0; t < 3; t++) begin
      int vl = (t == 2) ? 0 : 1;
      logic [MAX_VL-1:0] pred = (t == 0) ? 8'h01 : ((t == 1) ? 8'hFE : 8'hFF);
      int r0;
      load(16'h5A5A);
      cur_vl = vl; cur_pred = pred;
      r0 = reads;
      @(negedge clk_i);
      vl_i = VW'(vl); pred_i = pred; start_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
      wait_done(0, lat);
      chk(lat == 0 && reads == r0, "R9 immediate done without access", lat, 0);
      chk(res_valid_o == (vl == 1 && pred[0]), "R9 validity", res_valid_o, vl == 1 && pred[0]);
      if (vl == 1) chk(res_idx_o == '0, "R9 index zero", res_idx_o, 0);
      @(negedge clk_i);
    end

    abort_resume(0);
    abort_resume(3);
    abort_resume(5);

    chk(viol5 == 0 && reads > 0, "R5 read port discipline", viol5, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule